// File: doc/BRIEF.md
# I2C Byte-Array Target with Persistent Address Counter

This block is an I2C target in front of a 256-byte internal array. It keeps one address counter that survives across transactions. The counter always points one past the byte most recently read or written. A read that carries no byte address therefore continues from where the last access stopped. A read that follows a short "dummy" write fetches from the address given in that write. Each master acknowledge during a read streams the next byte, and the counter wraps from the top of the array back to zero.

Byte writes are also accepted, so that a test environment can load the array over the same two wires. The byte after the device address loads the counter. Each further byte is stored at the counter address, and the counter then advances.

SCL and SDA are sampled on the system clock through two-flop synchronizers. The only bus output is a pull-low enable for an open-drain SDA line.

Top module: `i2c_mem_target`

## Requirements
- R1: A synchronous reset sets the address counter to 0 and releases SDA (`sda_pull_o` = 0). It leaves the array contents untouched.
- R2: The target responds only to the 7-bit device address 7'b1010000, sent in the upper 7 bits of the first byte after a START, with R/W in bit 0. For any other address the target gives no ACK and keeps SDA released until the next START or STOP. The counter is not changed.
- R3: After a matching address byte, the target pulls SDA low for the whole ninth (ACK) clock.
- R4: In a write (R/W = 0), the target ACKs every byte. The first byte after the device address loads the counter. Each later byte is stored at the counter address, and the counter then increments modulo 256.
- R5: A START followed by the device address with R/W = 1 returns the byte at the counter, most significant bit first.
- R6: A write of only a byte address, followed by a repeated START and a read, returns the byte at that address.
- R7: During a read, each master ACK (SDA low in the ninth clock) makes the target send the byte at the next address. Address 255 is followed by address 0, so the whole array can be read in one transaction.
- R8: The target keeps SDA released during the master's ACK/NACK slot. After a NACK it drives nothing more until the next START.
- R9: The target changes `sda_pull_o` only while the synchronized SCL is low.
- R10: A repeated START in any state abandons the byte in progress without storing it and restarts address reception. The counter keeps its value.
- R11: A STOP in any state returns the target to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | SCL level sampled from the bus |
| sda_i | input | 1 | SDA level sampled from the bus |
| sda_pull_o | output | 1 | 1 = pull the open-drain SDA line low |

## Verification
The array is first loaded through one write that covers all 256 addresses, using a data pattern computed from the address. Every later read can then be checked against that pattern.

The reads are chosen to separate the ways the counter can move:
- Bare reads taken back to back, and a bare read taken after a reset, separate "counter persists" from "counter restarts at 0".
- A random read that starts near the top of the array, and a full 256-byte burst, separate a correct wrap from a truncated or saturating counter.

Other sequences target specific rules:
- A foreign address, an aborted half byte followed by a repeated START, and a STOP placed right after the byte address each check that the counter and the array stay as the rules require.
- Extra clocks sent after a NACK check that the target stays silent once the master has ended the read.

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter logic [6:0] DEV_ADDR = 7'b1010000,
  parameter int         AW       = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_ACKD, S_ADDR, S_ACKA, S_WDAT, S_ACKW, S_TX, S_MACK
  } st_t;

  st_t           st;
  logic [2:0]    scl_q, sda_q;
  logic [3:0]    cnt;
  logic [7:0]    sh, txsh;
  logic [AW-1:0] ptr;
  logic          rw, mack;
  logic [7:0]    mem [DEPTH];

  logic scl_s, scl_d, sda_s, sda_d;
  logic start, stop, scl_rise, scl_fall, byte_end, mem_we;
  logic idle_w, dev_w, mack_w;

  assign scl_s    = scl_q[1];
  assign scl_d    = scl_q[2];
  assign sda_s    = sda_q[1];
  assign sda_d    = sda_q[2];
  assign start    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop     = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign byte_end = scl_fall && cnt == 4'd8;
  assign mem_we   = st == S_WDAT && byte_end && !start && !stop;
  assign idle_w   = st == S_IDLE;
  assign dev_w    = st == S_DEV;
  assign mack_w   = st == S_MACK;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[ptr] <= sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      sh         <= '0;
      txsh       <= '0;
      ptr        <= '0;
      rw         <= 1'b0;
      mack       <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (start) begin
      st         <= S_DEV;
      cnt        <= '0;
      sda_pull_o <= 1'b0;
    end else if (stop) begin
      st         <= S_IDLE;
      sda_pull_o <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_ADDR, S_WDAT: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_end) begin
            cnt <= '0;
            if (st == S_DEV) begin
              if (sh[7:1] == DEV_ADDR) begin
                rw         <= sh[0];
                st         <= S_ACKD;
                sda_pull_o <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              if (st == S_ADDR) ptr <= sh[AW-1:0];
              else              ptr <= ptr + 1'b1;
              st         <= (st == S_ADDR) ? S_ACKA : S_ACKW;
              sda_pull_o <= 1'b1;
            end
          end
        end
        S_ACKD, S_ACKA, S_ACKW: begin
          if (scl_fall) begin
            cnt <= '0;
            if (st == S_ACKD && rw) begin
              st         <= S_TX;
              txsh       <= mem[ptr];
              sda_pull_o <= ~mem[ptr][7];
            end else begin
              st         <= (st == S_ACKD) ? S_ADDR : S_WDAT;
              sda_pull_o <= 1'b0;
            end
          end
        end
        S_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (byte_end) begin
            st         <= S_MACK;
            ptr        <= ptr + 1'b1;
            sda_pull_o <= 1'b0;
          end else if (scl_fall) begin
            txsh       <= {txsh[6:0], 1'b0};
            sda_pull_o <= ~txsh[6];
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            cnt <= '0;
            if (mack) begin
              st         <= S_TX;
              txsh       <= mem[ptr];
              sda_pull_o <= ~mem[ptr][7];
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: sda_pull_o <= 1'b0;
      endcase
    end
  end
endmodule

module i2c_mem_target_chk #(parameter int AW = 8) (
  input logic          clk,
  input logic          rst,
  input logic          scl_s,
  input logic          start,
  input logic          stop,
  input logic          sda_pull_o,
  input logic          idle_w,
  input logic          dev_w,
  input logic          mack_w,
  input logic [AW-1:0] ptr
);
  assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_s));

  assert_stop_release_R11: assert property (@(posedge clk) disable iff (rst)
    stop |=> (idle_w && !sda_pull_o));

  assert_start_restart_R10: assert property (@(posedge clk) disable iff (rst)
    start |=> dev_w);

  assert_idle_silent_R2: assert property (@(posedge clk) disable iff (rst)
    idle_w |-> !sda_pull_o);

  assert_mack_release_R8: assert property (@(posedge clk) disable iff (rst)
    mack_w |-> !sda_pull_o);

  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(mack_w) |-> ptr == $past(ptr) + 1'b1);
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start(start), .stop(stop),
  .sda_pull_o(sda_pull_o), .idle_w(idle_w), .dev_w(dev_w),
  .mack_w(mack_w), .ptr(ptr)
);

// File: tb/test_i2c_mem_target.sv
module test_i2c_mem_target;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull_o;
  logic sda_bus;
  int   tests = 0;
  int   fails = 0;
  int   viol = 0;
  logic prev_pull = 1'b0;

  assign sda_bus = sda_m & ~sda_pull_o;

  always #2 clk = ~clk;

  i2c_mem_target i_i2c_mem_target (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_pull_o(sda_pull_o)
  );

  always @(posedge clk) begin
    if (!rst && sda_pull_o != prev_pull && scl_m) viol++;
    prev_pull <= sda_pull_o;
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b0; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b1; wq(1);
  endtask

  task automatic wbit(input logic b);
    sda_m = b;    wq(1);
    scl_m = 1'b1; wq(2);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    b = sda_bus;  wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] v, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      v[i] = b;
    end
    wbit(~ack);
  endtask

  task automatic cur_read(input string req, input int exp_addr);
    logic ack;
    logic [7:0] v;
    bus_start();
    wbyte(8'hA1, ack);
    chk("R3", ack, 1);
    rbyte(v, 1'b0);
    bus_stop();
    chk(req, v, pat(exp_addr));
  endtask

  initial begin
    logic ack, b;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    wq(2);
    chk("R1", sda_pull_o, 0);

    // R4: load the whole array in one write starting at address 0
    bus_start();
    wbyte(8'hA0, ack); chk("R3", ack, 1);
    wbyte(8'h00, ack); chk("R4", ack, 1);
    for (int a = 0; a < 256; a++) begin
      wbyte(pat(a), ack);
      if (!ack) chk("R4", ack, 1);
    end
    bus_stop();

    cur_read("R5", 0);
    cur_read("R5", 1);

    // R1: reset puts the counter back to 0, array kept
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", sda_pull_o, 0);
    wq(1);
    cur_read("R1", 0);

    // R6/R7: random read at 0xF0 crossing the top of the array
    bus_start();
    wbyte(8'hA0, ack); chk("R3", ack, 1);
    wbyte(8'hF0, ack); chk("R6", ack, 1);
    bus_start();
    wbyte(8'hA1, ack); chk("R6", ack, 1);
    for (int i = 0; i < 20; i++) begin
      rbyte(v, i != 19);
      chk(i == 0 ? "R6" : "R7", v, pat((8'hF0 + i) & 255));
    end
    bus_stop();

    // R7: one burst over the whole array, starting at the counter (4)
    bus_start();
    wbyte(8'hA1, ack); chk("R3", ack, 1);
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) begin
        rbyte(v, i != 255);
        if (v != pat((4 + i) & 255)) begin
          bad++;
          chk("R7", v, pat((4 + i) & 255));
        end
      end
      chk("R7", bad, 0);
    end
    bus_stop();

    // R2: foreign addresses get no ACK and do not move the counter
    bus_start();
    wbyte(8'hA2, ack); chk("R2", ack, 0);
    wbyte(8'h00, ack); chk("R2", ack, 0);
    bus_start();
    wbyte(8'h51, ack); chk("R2", ack, 0);
    rbit(b); chk("R2", b, 1);
    bus_stop();
    cur_read("R2", 4);

    // R10: half a data byte, then repeated START
    bus_start();
    wbyte(8'hA0, ack);
    wbyte(8'h10, ack); chk("R4", ack, 1);
    wbit(1'b0); wbit(1'b0); wbit(1'b0); wbit(1'b0);
    bus_start();
    wbyte(8'hA1, ack); chk("R10", ack, 1);
    rbyte(v, 1'b0);
    bus_stop();
    chk("R10", v, pat(8'h10));

    // R4: single byte write then check counter and the stored value
    bus_start();
    wbyte(8'hA0, ack);
    wbyte(8'h20, ack);
    wbyte(8'h5A, ack); chk("R4", ack, 1);
    bus_stop();
    cur_read("R4", 8'h21);
    bus_start();
    wbyte(8'hA0, ack);
    wbyte(8'h20, ack);
    bus_start();
    wbyte(8'hA1, ack);
    rbyte(v, 1'b0);
    bus_stop();
    chk("R4", v, 8'h5A);

    // R8: after a NACK the target stays off the line
    bus_start();
    wbyte(8'hA1, ack);
    rbyte(v, 1'b0);
    chk("R8", v, pat(8'h21));
    rbit(b); chk("R8", b, 1);
    rbit(b); chk("R8", b, 1);
    bus_stop();

    // R11: STOP right after the byte address
    bus_start();
    wbyte(8'hA0, ack);
    wbyte(8'h30, ack);
    bus_stop();
    wq(1);
    chk("R11", sda_pull_o, 0);
    cur_read("R11", 8'h30);

    chk("R9", viol, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule